// File: doc/BRIEF.md
# Banked Address Register File with Status Register

This block holds the pointer registers and the status word of a 32-bit CISC-style processor core. Seven general 32-bit pointer registers sit at indices 0 to 6. Index 7 is the stack pointer slot. It is backed by two physical registers, one for user mode and one for supervisor mode. The supervisor bit of the status word decides which of the two a read or a write at index 7 reaches.

Two combinational read ports and one write port serve the pointer registers. Each write carries a size flag. A long write stores all 32 bits. A word write sign-extends bit 15 across the upper half. The status word has its own write port, and the privilege level limits what that port may change. A branch-condition output evaluates one of sixteen tests against the condition flags. A program counter register keeps 32 bits and drives the low 24 bits as the external address.

Privilege is held as a two-state machine: `MODE_SUPER` (S=1, the reset state) and `MODE_USER` (S=0). The transition *drop_to_user* runs from `MODE_SUPER` to `MODE_USER` when a status write in supervisor mode clears S. The transition *stay_super* keeps `MODE_SUPER` for every other cycle in that state. The transition *stay_user* holds `MODE_USER` on every cycle, because only reset leads back to supervisor mode within this block.

Top module: `addr_reg_file`

## Requirements
- R1: After reset the status word reads 0x2700 (S=1, T=0, interrupt mask 7, flags clear), every pointer register and both stack registers read 0, and the external address is 0.
- R2: Index 7 reaches the supervisor stack register when S=1 and the user stack register when S=0. A write at index 7 leaves the other stack register unchanged.
- R3: A long write (`wr_long`=1) stores all 32 bits of `wr_data`. A word write (`wr_long`=0) stores `wr_data[15:0]` with bit 15 copied into bits 31:16.
- R4: S is bit 13 of the status word. A supervisor status write with bit 13 clear enters user mode, and later index-7 accesses use the user stack register. In user mode S stays 0.
- R5: In user mode a status write changes only the flag bits (C bit 0, V bit 1, Z bit 2, N bit 3, X bit 4). Bits 15:8 keep their value.
- R6: Status bits 5, 6, 7, 11, 12 and 14 always read 0. In supervisor mode a write of 0xFFFF reads back as 0xA71F.
- R7: A read of a register in the same cycle as a write to it returns the old value. The new value is visible from the next cycle.
- R8: `cond_true` evaluates `cond_sel` from the current flags. The codes are 0 T (1), 1 F (0), 2 HI (!C&!Z), 3 LS (C|Z), 4 CC (!C), 5 CS (C), 6 NE (!Z), 7 EQ (Z), 8 VC (!V), 9 VS (V), 10 PL (!N), 11 MI (N), 12 GE (N==V), 13 LT (N!=V), 14 GT (N==V & !Z), 15 LE (Z | N!=V).
- R9: `pc_we` loads the 32-bit program counter from `pc_wdata`. `pc_addr` shows its bits 23:0 from the next cycle.
- R10: The two read ports work independently and can return different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 3 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 3 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Pointer register write enable |
| wr_idx | input | 3 | Write register index |
| wr_long | input | 1 | 1 = long write, 0 = sign-extended word write |
| wr_data | input | 32 | Write data |
| sr_we | input | 1 | Status word write enable |
| sr_wdata | input | 16 | Status word write data |
| sr_rdata | output | 16 | Current status word |
| cond_sel | input | 4 | Condition test code |
| cond_true | output | 1 | Result of the selected test |
| pc_we | input | 1 | Program counter load enable |
| pc_wdata | input | 32 | Program counter load value |
| pc_addr | output | 24 | External address (counter bits 23:0) |

## Verification
The assertions take the write index to lie in 0 to 7. They also take the size flag to be valid whenever the write enable is high. They check user-mode stickiness on the assumption that nothing outside the block forces S back to 1. The stimulus changes every input half a cycle away from the active edge. It sends only legal indices and, after reset, never tries to re-enter supervisor mode through the status port. The condition table sets the flags only through supervisor writes that keep S=1, so the pointer state stays predictable between table entries.

// File: rtl/arf_pkg.sv
package arf_pkg;

    typedef enum logic [0:0] {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } priv_mode_e;

    typedef enum logic [3:0] {
        CND_T, CND_F, CND_HI, CND_LS, CND_CC, CND_CS, CND_NE, CND_EQ,
        CND_VC, CND_VS, CND_PL, CND_MI, CND_GE, CND_LT, CND_GT, CND_LE
    } cond_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int          SR_W        = 16;
    localparam int          FLAG_W      = 5;
    localparam int          BIT_S       = 13;
    localparam int          BIT_T       = 15;
    localparam int          IMASK_LO    = 8;
    localparam int          IMASK_W     = 3;
    localparam logic [15:0] SR_RESET    = 16'h2700;

endpackage

// File: rtl/arf_sreg.sv
module arf_sreg
    import arf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_we,
    input  logic [SR_W-1:0]  sr_wdata,
    output logic [SR_W-1:0]  sr_rdata,
    output priv_mode_e       mode,
    output flags_t           flags
);

    priv_mode_e           mode_q, mode_d;
    flags_t               flags_q;
    logic                 trace_q;
    logic [IMASK_W-1:0]   imask_q;

    // privilege state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_SUPER;
        else        mode_q <= mode_d;
    end

    // transitions: drop_to_user, stay_super, stay_user
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_SUPER: if (sr_we && !sr_wdata[BIT_S]) mode_d = MODE_USER;
            MODE_USER:  mode_d = MODE_USER;
            default:    mode_d = MODE_SUPER;
        endcase
    end

    // remaining status fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            trace_q <= SR_RESET[BIT_T];
            imask_q <= SR_RESET[IMASK_LO +: IMASK_W];
        end else if (sr_we) begin
            flags_q <= flags_t'(sr_wdata[FLAG_W-1:0]);
            if (mode_q == MODE_SUPER) begin
                trace_q <= sr_wdata[BIT_T];
                imask_q <= sr_wdata[IMASK_LO +: IMASK_W];
            end
        end
    end

    // outputs
    always_comb begin
        sr_rdata                        = '0;
        sr_rdata[FLAG_W-1:0]            = flags_q;
        sr_rdata[IMASK_LO +: IMASK_W]   = imask_q;
        sr_rdata[BIT_S]                 = (mode_q == MODE_SUPER);
        sr_rdata[BIT_T]                 = trace_q;
        mode                            = mode_q;
        flags                           = flags_q;
    end

    // R5: a user-mode write leaves the system byte alone
    a_r5_sys_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && mode_q == MODE_USER) |=> $stable(sr_rdata[SR_W-1:8]));

    // R4: user mode is left only through reset
    a_r4_user_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_USER) |=> (sr_rdata[BIT_S] == 1'b0));

endmodule

// File: rtl/arf_bank.sv
module arf_bank
    import arf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_PTR = 7,
    parameter int WORD_W  = 16,
    localparam int IDX_W  = $clog2(NUM_PTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  priv_mode_e        mode,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_long,
    input  logic [DATA_W-1:0] wr_data
);

    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_PTR);

    logic [DATA_W-1:0] ptr_q [NUM_PTR];
    logic [DATA_W-1:0] usp_q, ssp_q;
    logic [DATA_W-1:0] wr_val;
    logic              wr_sp;

    assign wr_val = wr_long ? wr_data
                            : {{(DATA_W-WORD_W){wr_data[WORD_W-1]}}, wr_data[WORD_W-1:0]};
    assign wr_sp  = wr_en && (wr_idx == SP_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PTR; i++) ptr_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PTR; i++)
                if (wr_idx == IDX_W'(i)) ptr_q[i] <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usp_q <= '0;
            ssp_q <= '0;
        end else if (wr_sp) begin
            if (mode == MODE_SUPER) ssp_q <= wr_val;
            else                    usp_q <= wr_val;
        end
    end

    function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_PTR; i++)
            if (idx == IDX_W'(i)) r = ptr_q[i];
        if (idx == SP_IDX) r = (mode == MODE_SUPER) ? ssp_q : usp_q;
        return r;
    endfunction

    assign rd_a_data = pick(rd_a_idx);
    assign rd_b_data = pick(rd_b_idx);

    // R3: word writes land sign-extended
    a_r3_word_sext: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_long && wr_idx < SP_IDX) |=>
        (ptr_q[$past(wr_idx)] ==
         {{(DATA_W-WORD_W){$past(wr_data[WORD_W-1])}}, $past(wr_data[WORD_W-1:0])}));

    // R2: supervisor stack writes never reach the user stack
    a_r2_user_stack_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sp && mode == MODE_SUPER) |=> $stable(usp_q));

    // R2: user stack writes never reach the supervisor stack
    a_r2_super_stack_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sp && mode == MODE_USER) |=> $stable(ssp_q));

endmodule

// File: rtl/arf_cond.sv
module arf_cond
    import arf_pkg::*;
(
    input  flags_t flags,
    input  cond_e  sel,
    output logic   hit
);

    logic nv_eq;
    assign nv_eq = (flags.n == flags.v);

    always_comb begin
        hit = 1'b0;
        unique case (sel)
            CND_T:  hit = 1'b1;
            CND_F:  hit = 1'b0;
            CND_HI: hit = !flags.c && !flags.z;
            CND_LS: hit = flags.c || flags.z;
            CND_CC: hit = !flags.c;
            CND_CS: hit = flags.c;
            CND_NE: hit = !flags.z;
            CND_EQ: hit = flags.z;
            CND_VC: hit = !flags.v;
            CND_VS: hit = flags.v;
            CND_PL: hit = !flags.n;
            CND_MI: hit = flags.n;
            CND_GE: hit = nv_eq;
            CND_LT: hit = !nv_eq;
            CND_GT: hit = nv_eq && !flags.z;
            CND_LE: hit = flags.z || !nv_eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/addr_reg_file.sv
module addr_reg_file
    import arf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_PTR = 7,
    parameter int ADDR_W  = 24,
    localparam int IDX_W  = $clog2(NUM_PTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_long,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sr_we,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic [SR_W-1:0]   sr_rdata,
    input  logic [3:0]        cond_sel,
    output logic              cond_true,
    input  logic              pc_we,
    input  logic [DATA_W-1:0] pc_wdata,
    output logic [ADDR_W-1:0] pc_addr
);

    priv_mode_e        mode;
    flags_t            flags;
    logic [DATA_W-1:0] pc_q;

    arf_sreg u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sr_we    (sr_we),
        .sr_wdata (sr_wdata),
        .sr_rdata (sr_rdata),
        .mode     (mode),
        .flags    (flags)
    );

    arf_bank #(.DATA_W(DATA_W), .NUM_PTR(NUM_PTR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .rd_a_idx  (rd_a_idx),
        .rd_b_idx  (rd_b_idx),
        .rd_a_data (rd_a_data),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_long   (wr_long),
        .wr_data   (wr_data)
    );

    arf_cond u_cond (
        .flags (flags),
        .sel   (cond_e'(cond_sel)),
        .hit   (cond_true)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_wdata;
    end

    assign pc_addr = pc_q[ADDR_W-1:0];

    // R9: the full counter is kept, the address shows its low part
    a_r9_pc_full: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (pc_q == $past(pc_wdata)));

endmodule

// File: tb/tb_addr_reg_file.sv
module tb_addr_reg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_wdata = '0;
    logic        wr_en = 1'b0, wr_long = 1'b0, sr_we = 1'b0, pc_we = 1'b0;
    logic [15:0] sr_wdata = '0, sr_rdata;
    logic [3:0]  cond_sel = '0;
    logic        cond_true;
    logic [23:0] pc_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    addr_reg_file dut (.*);

    // {flags[4:0] (X N Z V C), cond code, expected}
    localparam int NV = 24;
    localparam logic [9:0] VEC [NV] = '{
        {5'h00, 4'd0,  1'b1}, {5'h00, 4'd1,  1'b0}, {5'h00, 4'd2,  1'b1},
        {5'h00, 4'd3,  1'b0}, {5'h01, 4'd2,  1'b0}, {5'h01, 4'd3,  1'b1},
        {5'h01, 4'd4,  1'b0}, {5'h01, 4'd5,  1'b1}, {5'h04, 4'd6,  1'b0},
        {5'h04, 4'd7,  1'b1}, {5'h02, 4'd8,  1'b0}, {5'h02, 4'd9,  1'b1},
        {5'h08, 4'd10, 1'b0}, {5'h08, 4'd11, 1'b1}, {5'h08, 4'd12, 1'b0},
        {5'h08, 4'd13, 1'b1}, {5'h0A, 4'd12, 1'b1}, {5'h0A, 4'd14, 1'b1},
        {5'h0E, 4'd14, 1'b0}, {5'h0E, 4'd15, 1'b1}, {5'h00, 4'd15, 1'b0},
        {5'h02, 4'd15, 1'b1}, {5'h04, 4'd2,  1'b0}, {5'h10, 4'd7,  1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] idx, input logic lng, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_long = lng; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sr_write(input logic [15:0] v);
        @(negedge clk);
        sr_we = 1'b1; sr_wdata = v;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic read_a(input logic [2:0] idx, input string req, input logic [31:0] exp);
        rd_a_idx = idx;
        #1;
        check(req, rd_a_data, exp);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog got hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sr", {16'h0, sr_rdata}, 32'h2700);
        for (int i = 0; i < 8; i++) read_a(3'(i), "R1 reg", 32'h0);
        check("R1 pc", {8'h0, pc_addr}, 32'h0);

        // R8 condition table, flags set through supervisor writes
        for (int k = 0; k < NV; k++) begin
            sr_write(16'h2700 | {11'h0, VEC[k][9:5]});
            cond_sel = VEC[k][4:1];
            #1;
            check("R8 cond", {31'h0, cond_true}, {31'h0, VEC[k][0]});
        end

        // R3 long and word writes
        reg_write(3'd3, 1'b1, 32'h1234_5678);
        read_a(3'd3, "R3 long", 32'h1234_5678);
        reg_write(3'd4, 1'b0, 32'h0000_8001);
        read_a(3'd4, "R3 word neg", 32'hFFFF_8001);
        reg_write(3'd5, 1'b0, 32'hABCD_7FFF);
        read_a(3'd5, "R3 word pos", 32'h0000_7FFF);

        // R10 two ports at once
        rd_a_idx = 3'd3; rd_b_idx = 3'd4;
        #1;
        check("R10 port a", rd_a_data, 32'h1234_5678);
        check("R10 port b", rd_b_data, 32'hFFFF_8001);

        // R7 same-cycle read returns old value
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_long = 1'b1; wr_data = 32'hDEAD_BEEF;
        rd_a_idx = 3'd3;
        #1;
        check("R7 old", rd_a_data, 32'h1234_5678);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R7 new", rd_a_data, 32'hDEAD_BEEF);

        // R6 reserved bits
        sr_write(16'hFFFF);
        #1;
        check("R6 reserved", {16'h0, sr_rdata}, 32'h0000_A71F);
        sr_write(16'h2700);

        // R2 supervisor stack
        reg_write(3'd7, 1'b1, 32'h0000_1000);
        read_a(3'd7, "R2 ssp", 32'h0000_1000);

        // R4 drop to user
        sr_write(16'h0000);
        #1;
        check("R4 s clear", {16'h0, sr_rdata}, 32'h0);
        read_a(3'd7, "R2 usp untouched", 32'h0);
        reg_write(3'd7, 1'b1, 32'h0000_2000);
        read_a(3'd7, "R2 usp", 32'h0000_2000);

        // R5 user write touches only flags
        sr_write(16'hFFFF);
        #1;
        check("R5 user write", {16'h0, sr_rdata}, 32'h0000_001F);
        check("R4 stays user", {31'h0, sr_rdata[13]}, 32'h0);
        read_a(3'd7, "R4 usp active", 32'h0000_2000);

        // R9 program counter
        @(negedge clk);
        pc_we = 1'b1; pc_wdata = 32'hAB12_3456;
        @(negedge clk);
        pc_we = 1'b0;
        #1;
        check("R9 pc addr", {8'h0, pc_addr}, 32'h0012_3456);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule